// File: doc/BRIEF.md
# EPROM Programming Sequencer

This block is the host-side controller that writes a serial EPROM target one word at a time. It drives a lower-level command engine with abstract requests: enter program mode, load a configuration pointer, load a data word, begin a pulse, end a pulse, read back, and step the address. It applies adaptive programming pulses to each word. Each pulse is followed by a read-back. Once the word reads back correctly after N pulses, the block adds 3N over-programming pulses. A word that still fails after the retry cap is reported as a programming failure.

After every word is written, the sequencer runs two verification passes over all words. The first pass runs with the supply select at the low corner and the second at the high corner. Each corner has its own error code. In configuration mode the sequencer programs four identification words and then a configuration word. It steps the address across the three reserved slots between them, and it gives the configuration word a fixed number of pulses. The pulse duration is a counter derived from the clock frequency. Words come from an external source indexed by `word_idx_o`.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, busy_o is 0, status_o is 0 (none), cmd_valid_o is 0 and vdd_sel_o is 0 (nominal).
- R2: Each program cycle is a LOAD_DATA request (cmd code 2) carrying the word, then BEGIN (code 5), then prog_pulse_o high for exactly PULSE_CYCLES = CLK_FREQ_HZ/1000*PULSE_US/1000 cycles, then END (code 6). vdd_sel_o is 0 at every BEGIN.
- R3: In adaptive mode, every pulse is followed by a READ (code 3). If the read matches the word after N pulses, exactly 3N more program cycles follow with no reads, so the word receives 4N pulses in total.
- R4: If the read-back still mismatches after MAX_TRIES pulses, status_o becomes 2. busy_o drops, and no later word receives any pulse.
- R5: After each word an INC request (code 4) is issued. Words are taken in ascending word_idx_o order, and each word is written with word_i at that index.
- R6: After programming, each pass starts with ENTER (code 0, target address back to 0). Every word is read at vdd_sel_o = 1 (minimum) and then at vdd_sel_o = 2 (maximum). A mismatch ends the run with status 3 (minimum pass) or status 4 (maximum pass). If every read matches, the status is 1.
- R7: With cfg_space_i = 1, the sequencer issues LOAD_CFG (code 1) after ENTER. It programs five words: idx 0..3 adaptively at offsets 0..3 and idx 4 at offset 7. It reaches offset 7 through four INC requests after idx 3. idx 4 receives exactly CFG_PULSES pulses. count_i is ignored in this mode.
- R8: busy_o is high from the cycle after start_i until a status is latched, and status_o reads 0 while busy. The latched status holds until the next start.
- R9: start_i with count_i = 0 and cfg_space_i = 0 latches status 1 without issuing any request.
- R10: A request stays asserted with unchanged cmd_o and cmd_data_o until cmd_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted while idle |
| cfg_space_i | input | 1 | 1 selects the ID/configuration sequence |
| count_i | input | AW | Number of words in user mode |
| word_idx_o | output | AW | Index of the current word at the word source |
| word_i | input | DW | Word from the source at word_idx_o |
| cmd_valid_o | output | 1 | Request to the command engine |
| cmd_o | output | 3 | Request code (0 enter, 1 load cfg, 2 load data, 3 read, 4 inc, 5 begin, 6 end) |
| cmd_data_o | output | DW | Word carried by load requests |
| cmd_ack_i | input | 1 | Engine finished the current request |
| rd_data_i | input | DW | Read-back word, valid with the ack of a read |
| prog_pulse_o | output | 1 | High during the timed programming pulse |
| vdd_sel_o | output | 2 | Supply select: 0 nominal, 1 minimum, 2 maximum |
| busy_o | output | 1 | Sequence in progress |
| status_o | output | 3 | 0 none, 1 done, 2 program fail, 3 low-corner fail, 4 high-corner fail |

## Verification
A bench model of the target gives each word a number of pulses it needs before it reads back. It uses random needs between 1 and the cap and also the two ends of that range, which separates the 4N total from off-by-one retry or over-program counts. A need one above the cap distinguishes the retry limit and confirms that later words stay untouched. Faults injected only at one supply corner tell the two verify error codes apart. A configuration-mode run checks the address gap and the fixed pulse count of the configuration word.

// File: rtl/eprom_prog_pkg.sv
`timescale 1ns/1ps
package eprom_prog_pkg;
  typedef enum logic [2:0] {
    CMD_ENTER     = 3'd0,
    CMD_LOAD_CFG  = 3'd1,
    CMD_LOAD_DATA = 3'd2,
    CMD_READ      = 3'd3,
    CMD_INC       = 3'd4,
    CMD_BEGIN     = 3'd5,
    CMD_END       = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    ST_NONE      = 3'd0,
    ST_OK        = 3'd1,
    ST_PROG_FAIL = 3'd2,
    ST_VMIN_FAIL = 3'd3,
    ST_VMAX_FAIL = 3'd4
  } status_e;

  typedef enum logic [1:0] {
    VDD_NOM = 2'd0,
    VDD_MIN = 2'd1,
    VDD_MAX = 2'd2
  } vdd_e;

  localparam int unsigned ID_WORDS  = 4;
  localparam int unsigned CFG_WORDS = ID_WORDS + 1;
  // increments from the last ID word to the configuration word
  localparam int unsigned CFG_GAP   = 4;
endpackage

// File: rtl/eprom_pulse_timer.sv
`timescale 1ns/1ps
module eprom_pulse_timer #(
  parameter int unsigned CYCLES = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= CW'(CYCLES - 1);
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = act_q && (cnt_q == '0);

  p_start_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !act_q);
  p_done_ends_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !act_q);
endmodule

// File: rtl/eprom_prog_fsm.sv
`timescale 1ns/1ps
module eprom_prog_fsm
  import eprom_prog_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned DW         = 14,
  parameter int unsigned MAX_TRIES  = 25,
  parameter int unsigned CFG_PULSES = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cfg_space_i,
  input  logic [AW-1:0] count_i,
  output logic [AW-1:0] word_idx_o,
  input  logic [DW-1:0] word_i,
  output logic          cmd_valid_o,
  output logic [2:0]    cmd_o,
  output logic [DW-1:0] cmd_data_o,
  input  logic          cmd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          tmr_start_o,
  input  logic          tmr_done_i,
  output logic          prog_pulse_o,
  output logic [1:0]    vdd_sel_o,
  output logic          busy_o,
  output logic [2:0]    status_o
);
  localparam int unsigned TW   = $clog2(MAX_TRIES + 1);
  localparam int unsigned EMAX = (3 * MAX_TRIES > CFG_PULSES) ? 3 * MAX_TRIES : CFG_PULSES;
  localparam int unsigned EW   = $clog2(EMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ENTER, S_LDCFG, S_LOAD, S_BEGIN, S_WAIT, S_END, S_READ, S_VREAD, S_INC
  } state_e;
  typedef enum logic [1:0] {P_PROG, P_VMIN, P_VMAX} pass_e;
  typedef enum logic [1:0] {PH_ADAPT, PH_OVER, PH_FIXED} phase_e;

  state_e        state_q;
  pass_e         pass_q;
  phase_e        phase_q;
  status_e       status_q;
  vdd_e          vdd_q;
  logic [AW-1:0] idx_q, last_q;
  logic [TW-1:0] n_q;
  logic [EW-1:0] extra_q;
  logic [2:0]    inc_left_q;
  logic          cfg_q, busy_q;

  logic          ack, last_loc, rd_match, nxt_is_cfgw;
  logic [AW-1:0] idx_nxt;
  logic [2:0]    inc_init;

  assign ack         = cmd_valid_o && cmd_ack_i;
  assign last_loc    = (idx_q == last_q);
  assign idx_nxt     = idx_q + 1'b1;
  assign nxt_is_cfgw = cfg_q && (idx_nxt == AW'(ID_WORDS));
  assign rd_match    = (rd_data_i == word_i);
  assign inc_init    = (cfg_q && idx_q == AW'(ID_WORDS - 1)) ? 3'(CFG_GAP) : 3'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      pass_q     <= P_PROG;
      phase_q    <= PH_ADAPT;
      status_q   <= ST_NONE;
      vdd_q      <= VDD_NOM;
      idx_q      <= '0;
      last_q     <= '0;
      n_q        <= '0;
      extra_q    <= '0;
      inc_left_q <= 3'd1;
      cfg_q      <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          status_q <= ST_NONE;
          cfg_q    <= cfg_space_i;
          idx_q    <= '0;
          n_q      <= '0;
          if (!cfg_space_i && count_i == '0) begin
            status_q <= ST_OK;
          end else begin
            busy_q  <= 1'b1;
            pass_q  <= P_PROG;
            vdd_q   <= VDD_NOM;
            last_q  <= cfg_space_i ? AW'(CFG_WORDS - 1) : count_i - 1'b1;
            state_q <= S_ENTER;
          end
        end
        S_ENTER: if (ack) begin
          idx_q   <= '0;
          n_q     <= '0;
          phase_q <= PH_ADAPT;
          if (cfg_q)                 state_q <= S_LDCFG;
          else if (pass_q == P_PROG) state_q <= S_LOAD;
          else                       state_q <= S_VREAD;
        end
        S_LDCFG: if (ack) state_q <= (pass_q == P_PROG) ? S_LOAD : S_VREAD;
        S_LOAD:  if (ack) state_q <= S_BEGIN;
        S_BEGIN: if (ack) state_q <= S_WAIT;
        S_WAIT:  if (tmr_done_i) state_q <= S_END;
        S_END: if (ack) begin
          if (phase_q == PH_ADAPT) begin
            n_q     <= n_q + 1'b1;
            state_q <= S_READ;
          end else if (extra_q == EW'(1)) begin
            inc_left_q <= inc_init;
            state_q    <= S_INC;
          end else begin
            extra_q <= extra_q - 1'b1;
            state_q <= S_LOAD;
          end
        end
        S_READ: if (ack) begin
          if (rd_match) begin
            phase_q <= PH_OVER;
            extra_q <= EW'(32'(n_q) * 3);
            state_q <= S_LOAD;
          end else if (32'(n_q) >= MAX_TRIES) begin
            status_q <= ST_PROG_FAIL;
            busy_q   <= 1'b0;
            vdd_q    <= VDD_NOM;
            state_q  <= S_IDLE;
          end else begin
            state_q <= S_LOAD;
          end
        end
        S_VREAD: if (ack) begin
          if (!rd_match) begin
            status_q <= (pass_q == P_VMIN) ? ST_VMIN_FAIL : ST_VMAX_FAIL;
            busy_q   <= 1'b0;
            vdd_q    <= VDD_NOM;
            state_q  <= S_IDLE;
          end else begin
            inc_left_q <= inc_init;
            state_q    <= S_INC;
          end
        end
        S_INC: if (ack) begin
          if (inc_left_q != 3'd1) begin
            inc_left_q <= inc_left_q - 1'b1;
          end else if (last_loc) begin
            unique case (pass_q)
              P_PROG: begin pass_q <= P_VMIN; vdd_q <= VDD_MIN; state_q <= S_ENTER; end
              P_VMIN: begin pass_q <= P_VMAX; vdd_q <= VDD_MAX; state_q <= S_ENTER; end
              default: begin
                status_q <= ST_OK;
                busy_q   <= 1'b0;
                vdd_q    <= VDD_NOM;
                state_q  <= S_IDLE;
              end
            endcase
          end else begin
            idx_q <= idx_nxt;
            n_q   <= '0;
            if (pass_q == P_PROG) begin
              phase_q <= nxt_is_cfgw ? PH_FIXED : PH_ADAPT;
              extra_q <= EW'(CFG_PULSES);
              state_q <= S_LOAD;
            end else begin
              state_q <= S_VREAD;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid_o = 1'b1;
    cmd_o       = CMD_ENTER;
    unique case (state_q)
      S_ENTER:         cmd_o = CMD_ENTER;
      S_LDCFG:         cmd_o = CMD_LOAD_CFG;
      S_LOAD:          cmd_o = CMD_LOAD_DATA;
      S_BEGIN:         cmd_o = CMD_BEGIN;
      S_END:           cmd_o = CMD_END;
      S_READ, S_VREAD: cmd_o = CMD_READ;
      S_INC:           cmd_o = CMD_INC;
      default:         cmd_valid_o = 1'b0;
    endcase
  end

  assign cmd_data_o   = (state_q == S_LOAD || state_q == S_LDCFG) ? word_i : '0;
  assign word_idx_o   = idx_q;
  assign tmr_start_o  = (state_q == S_BEGIN) && cmd_ack_i;
  assign prog_pulse_o = (state_q == S_WAIT);
  assign vdd_sel_o    = vdd_q;
  assign busy_o       = busy_q;
  assign status_o     = status_q;

  p_cmd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_o) && $stable(cmd_data_o));
  p_begin_nominal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_o == CMD_BEGIN |-> vdd_sel_o == VDD_NOM);
  p_tries_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(n_q) <= MAX_TRIES);
  p_busy_no_status_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> status_o == ST_NONE);
  p_verify_corner_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_VREAD |-> vdd_sel_o != VDD_NOM);
endmodule

// File: rtl/eprom_prog_seq.sv
`timescale 1ns/1ps
module eprom_prog_seq #(
  parameter int unsigned AW          = 12,
  parameter int unsigned DW          = 14,
  parameter int unsigned CLK_FREQ_HZ = 200_000_000,
  parameter int unsigned PULSE_US    = 100,
  parameter int unsigned MAX_TRIES   = 25,
  parameter int unsigned CFG_PULSES  = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cfg_space_i,
  input  logic [AW-1:0] count_i,
  output logic [AW-1:0] word_idx_o,
  input  logic [DW-1:0] word_i,
  output logic          cmd_valid_o,
  output logic [2:0]    cmd_o,
  output logic [DW-1:0] cmd_data_o,
  input  logic          cmd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          prog_pulse_o,
  output logic [1:0]    vdd_sel_o,
  output logic          busy_o,
  output logic [2:0]    status_o
);
  localparam int unsigned PULSE_RAW    = (CLK_FREQ_HZ / 1000) * PULSE_US / 1000;
  localparam int unsigned PULSE_CYCLES = (PULSE_RAW < 1) ? 1 : PULSE_RAW;

  logic tmr_start, tmr_done;

  eprom_pulse_timer #(.CYCLES(PULSE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tmr_start),
    .done_o (tmr_done)
  );

  eprom_prog_fsm #(
    .AW(AW), .DW(DW), .MAX_TRIES(MAX_TRIES), .CFG_PULSES(CFG_PULSES)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .cfg_space_i (cfg_space_i),
    .count_i     (count_i),
    .word_idx_o  (word_idx_o),
    .word_i      (word_i),
    .cmd_valid_o (cmd_valid_o),
    .cmd_o       (cmd_o),
    .cmd_data_o  (cmd_data_o),
    .cmd_ack_i   (cmd_ack_i),
    .rd_data_i   (rd_data_i),
    .tmr_start_o (tmr_start),
    .tmr_done_i  (tmr_done),
    .prog_pulse_o(prog_pulse_o),
    .vdd_sel_o   (vdd_sel_o),
    .busy_o      (busy_o),
    .status_o    (status_o)
  );
endmodule

// File: tb/eprom_prog_seq_tb.sv
`timescale 1ns/1ps
module eprom_prog_seq_tb;
  localparam int AW = 6, DW = 14;
  // scaled clock parameter so a pulse lasts 8 cycles
  localparam int CLK_HZ = 80_000, PUS = 100, PCYC = 8, MAXT = 25, CFGP = 100;
  localparam int NS = 73;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, cfg = 1'b0;
  logic [AW-1:0] count = '0;
  logic [AW-1:0] word_idx;
  logic [DW-1:0] word, cmd_data, rd_data = '0;
  logic cmd_valid, ack = 1'b0, pulse, busy;
  logic [2:0] cmd, status;
  logic [1:0] vdd;

  logic [DW-1:0] tbl [64];
  logic [DW-1:0] written [NS];
  int pulses [NS];
  int need [NS];
  int pc = 0, bad_min = -1, bad_max = -1, ncmd = 0;
  logic [DW-1:0] latch = '0;
  bit loaded = 1'b0;
  int bad_seq = 0, bad_pw = 0, bad_hold = 0, bad_busy = 0, run_len = 0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;
  assign word = tbl[word_idx];

  eprom_prog_seq #(.AW(AW), .DW(DW), .CLK_FREQ_HZ(CLK_HZ), .PULSE_US(PUS),
                   .MAX_TRIES(MAXT), .CFG_PULSES(CFGP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_space_i(cfg), .count_i(count),
    .word_idx_o(word_idx), .word_i(word), .cmd_valid_o(cmd_valid), .cmd_o(cmd),
    .cmd_data_o(cmd_data), .cmd_ack_i(ack), .rd_data_i(rd_data), .prog_pulse_o(pulse),
    .vdd_sel_o(vdd), .busy_o(busy), .status_o(status));

  function automatic int slot_of(int a);
    if (a < 64) return a;
    if (a >= 32'h2000 && a <= 32'h2007) return 64 + a - 32'h2000;
    return 72;
  endfunction

  function automatic logic [DW-1:0] read_val();
    int s = slot_of(pc);
    logic [DW-1:0] v = (pulses[s] >= need[s]) ? written[s] : 14'h3fff;
    if (vdd == 2'd1 && s == bad_min) v = v ^ 14'h1;
    if (vdd == 2'd2 && s == bad_max) v = v ^ 14'h2;
    return v;
  endfunction

  function automatic int exp_pulses(int nd);
    return (nd > MAXT) ? MAXT : 4 * nd;
  endfunction

  task automatic apply_cmd();
    int s;
    ncmd++;
    case (cmd)
      3'd0: pc = 0;
      3'd1: begin pc = 32'h2000; latch = cmd_data; loaded = 1'b1; end
      3'd2: begin latch = cmd_data; loaded = 1'b1; end
      3'd3: rd_data = read_val();
      3'd4: pc = pc + 1;
      3'd5: begin
        s = slot_of(pc);
        pulses[s]++;
        written[s] = latch;
        if (!loaded || vdd != 2'd0) bad_seq++;
        loaded = 1'b0;
      end
      default: ;
    endcase
  endtask

  // command engine model
  initial begin
    forever begin
      @(negedge clk);
      ack = 1'b0;
      if (cmd_valid) begin
        automatic int d = $urandom_range(0, 2);
        automatic logic [2:0] c0 = cmd;
        automatic logic [DW-1:0] d0 = cmd_data;
        repeat (d) begin
          @(negedge clk);
          if (!cmd_valid || cmd != c0 || cmd_data != d0) bad_hold++;
        end
        apply_cmd();
        ack = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (pulse) run_len++;
    else if (run_len != 0) begin
      if (run_len != PCYC) bad_pw++;
      run_len = 0;
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < NS; s++) begin
      pulses[s] = 0; written[s] = 14'h3fff; need[s] = 1;
    end
    bad_min = -1; bad_max = -1; ncmd = 0; pc = 0; loaded = 1'b0;
  endtask

  task automatic run(input bit c, input int n);
    int w = 0;
    @(negedge clk);
    start = 1'b1; cfg = c; count = AW'(n);
    @(negedge clk);
    start = 1'b0;
    while (busy && w < 60000) begin
      if (status != 3'd0) bad_busy++;
      @(negedge clk);
      w++;
    end
    chk("R8", int'(w < 60000), 1, "run finished");
  endtask

  function automatic int exp_status(int n);
    for (int i = 0; i < n; i++) if (need[i] > MAXT) return 2;
    if (bad_min >= 0) return 3;
    if (bad_max >= 0) return 4;
    return 1;
  endfunction

  task automatic user_run(int n, int fail_at, int vmin_at, int vmax_at, bit directed);
    int fail_seen = 0;
    clear_model();
    for (int i = 0; i < 64; i++) tbl[i] = DW'($urandom) & 14'h1fff;
    for (int i = 0; i < n; i++) need[i] = $urandom_range(1, MAXT);
    if (directed) begin need[0] = 1; need[n-1] = MAXT; end
    if (fail_at >= 0) need[fail_at] = MAXT + 1;
    bad_min = vmin_at; bad_max = vmax_at;
    run(1'b0, n);
    chk((fail_at >= 0) ? "R4" : "R6", int'(status), exp_status(n), "status");
    for (int i = 0; i < n; i++) begin
      if (fail_seen) chk("R4", pulses[i], 0, "pulses after failed word");
      else chk("R3", pulses[i], exp_pulses(need[i]), "pulses per word");
      if (need[i] > MAXT) fail_seen = 1;
      else if (!fail_seen) chk("R5", int'(written[i]), int'(tbl[i]), "word written");
    end
    chk("R5", pulses[n], 0, "no word past count");
    repeat (4) @(negedge clk);
    chk("R8", int'(status), exp_status(n), "status held");
    chk("R8", int'(busy), 0, "busy low after status");
  endtask

  initial begin
    void'($urandom(32'd4242));
    clear_model();
    for (int i = 0; i < 64; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(busy), 0, "busy");
    chk("R1", int'(status), 0, "status");
    chk("R1", int'(cmd_valid), 0, "cmd_valid");
    chk("R1", int'(vdd), 0, "vdd_sel");

    // R9 zero count
    run(1'b0, 0);
    repeat (3) @(negedge clk);
    chk("R9", int'(status), 1, "status on empty run");
    chk("R9", ncmd, 0, "requests on empty run");

    user_run(6, -1, -1, -1, 1'b1);
    user_run(6, -1, -1, -1, 1'b0);
    user_run(3, -1, -1, -1, 1'b0);
    user_run(5, 2, -1, -1, 1'b0);  // R4 retry cap
    user_run(4, -1, 1, -1, 1'b0);  // R6 low corner fault
    user_run(4, -1, -1, 3, 1'b0);  // R6 high corner fault

    // R7 configuration sequence
    clear_model();
    for (int i = 0; i < 64; i++) tbl[i] = DW'($urandom) & 14'h1fff;
    for (int k = 0; k < 4; k++) need[64 + k] = $urandom_range(1, MAXT);
    run(1'b1, 0);
    chk("R7", int'(status), 1, "cfg status");
    for (int k = 0; k < 4; k++) begin
      chk("R7", pulses[64 + k], 4 * need[64 + k], "ID pulses");
      chk("R7", int'(written[64 + k]), int'(tbl[k]), "ID word");
    end
    for (int k = 4; k < 7; k++) chk("R7", pulses[64 + k], 0, "reserved slot pulses");
    chk("R7", pulses[71], CFGP, "config word pulses");
    chk("R7", int'(written[71]), int'(tbl[4]), "config word");
    chk("R7", pulses[0], 0, "user space untouched");

    chk("R2", bad_seq, 0, "begin without load or off nominal");
    chk("R2", bad_pw, 0, "pulse width errors");
    chk("R10", bad_hold, 0, "request changed before ack");
    chk("R8", bad_busy, 0, "status nonzero while busy");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog expired: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule